// File: doc/BRIEF.md
# Seconds Counter with Alarm and Layered Interrupt

This peripheral keeps wall time as a plain count of elapsed seconds. A prescaler divides the core clock down to a one-second tick, and the count moves forward by one on each tick. Software may load the count at any time; a load also restarts the prescaler, so the first increment after it arrives one full second later. A single alarm register is compared against the count. A per-source configuration word decides whether the alarm match, a once-per-second event or a faster periodic event reaches the status flag.

Events reach the interrupt line through two layers. The first is a status flag in the timekeeping region, acknowledged by writing a 1 to it. The second is a cause/mask word in a separate system region. Its cause bits are cleared by writing them as 0, and its mask bits gate the single interrupt output. An interrupt handler clears the cause, turns the source off and acknowledges the status. Every register write completes in one bus cycle with no wait state. Read data appears one cycle after the read strobe.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset, every readable register (status, configuration, alarm, time, system cause/mask) reads 0 and `irq_o` is low.
- R2: A write to the time register (timekeeping region, offset 0x0C) loads the count. The prescaler restarts from zero, so the count first increments on the clock edge exactly CLKS_PER_SEC cycles after the edge that took the write.
- R3: The count increments by exactly one per second and wraps from all-ones to zero.
- R4: When configuration bit 0 (alarm enable) is 1, status bit 0 is set on the tick at which the count becomes equal to the alarm register (offset 0x10).
- R5: When configuration bit 1 (periodic enable) is 1, status bit 0 is also set by a periodic event. Configuration bit 2 = 1 selects one event per second, on the seconds tick. Bit 2 = 0 selects one event every FAST_PERIOD clock cycles.
- R6: With the configuration word (offset 0x04) at 0, no alarm match and no periodic event sets status bit 0 or a cause bit.
- R7: Status (offset 0x00) bit 0 is cleared by writing 1 to bit 0; writing 0 has no effect. Bit 1 (second alarm) always reads 0. An event arriving in the same cycle as the acknowledge leaves the bit set.
- R8: In the system word (system region, offset 0x08), cause bit 0 is set together with status bit 0. Cause bits are cleared by a write with that bit at 0, and a write of 1 never sets them.
- R9: System-word bits 2 and 3 are read/write mask bits for causes 0 and 1. `irq_o` is high exactly while some cause bit is 1 and its mask bit is 1.
- R10: Read data is returned on the cycle after `bus_rd`. Unmapped offsets in either region read 0, and writes to them change nothing.
- R11: The alarm register reads back all 32 bits written; the configuration word keeps only bits 2:0 and reads the rest as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sys | input | 1 | Region select: 0 timekeeping registers, 1 system interrupt word |
| bus_addr | input | ADDR_W | Byte offset within the selected region |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Combined, masked interrupt request |

## Verification
A prescaler that slips, or fails to restart on a load, shows up as a time readback that steps one cycle early or late around the expected second boundary. It also moves the first alarm interrupt away from exactly two seconds after a load to an alarm two seconds ahead. A status or cause bit in the wrong state shows as soon as the next read of either region, and through `irq_o` in the same cycle. Checking both layers separately tells an acknowledge on the wrong layer apart from a mask that is stuck: `irq_o` must stay high after the status acknowledge and fall only after the cause write.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   localparam int unsigned BUS_W   = 32;
   localparam int unsigned NUM_SRC = 2;

   // timekeeping region offsets
   localparam logic [7:0] OFS_STATUS = 8'h00;
   localparam logic [7:0] OFS_ICFG   = 8'h04;
   localparam logic [7:0] OFS_TIME   = 8'h0C;
   localparam logic [7:0] OFS_ALARM  = 8'h10;
   // system region offset
   localparam logic [7:0] OFS_SYSINT = 8'h08;

   // configuration word, bit 0 alarm, bit 1 periodic, bit 2 rate
   typedef struct packed {
      logic rate_1hz;
      logic per_en;
      logic alm_en;
   } icfg_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_ICFG,
      SEL_TIME,
      SEL_ALARM,
      SEL_SYSINT
   } reg_sel_e;

endpackage

// File: rtl/rtc_sec_timebase.sv
module rtc_sec_timebase #(
   parameter int unsigned CLKS_PER_SEC = 32768,
   parameter int unsigned FAST_PERIOD  = 256,
   parameter int unsigned TIME_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [TIME_W-1:0] load_val_i,
   output logic [TIME_W-1:0] count_o,
   output logic              sec_tick_o,
   output logic              fast_tick_o
);
   localparam int unsigned PRE_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_SEC - 1);

   if (CLKS_PER_SEC < 2) begin : g_bad_cps
      $error("CLKS_PER_SEC must be at least 2");
   end
   if (FAST_PERIOD < 2 || FAST_PERIOD > CLKS_PER_SEC) begin : g_bad_fast
      $error("FAST_PERIOD must lie in 2..CLKS_PER_SEC");
   end
   if ((CLKS_PER_SEC % FAST_PERIOD) != 0) begin : g_bad_ratio
      $error("CLKS_PER_SEC must be a multiple of FAST_PERIOD");
   end

   logic [PRE_W-1:0]  pre_q;
   logic [TIME_W-1:0] cnt_q;
   logic              at_last;

   assign at_last    = (pre_q == PRE_LAST);
   assign sec_tick_o = at_last && !load_i;
   assign count_o    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         pre_q <= '0;
         cnt_q <= load_val_i;
      end else if (at_last) begin
         pre_q <= '0;
         cnt_q <= cnt_q + TIME_W'(1);
      end else begin
         pre_q <= pre_q + PRE_W'(1);
      end
   end

   if (FAST_PERIOD == CLKS_PER_SEC) begin : g_fast_same
      assign fast_tick_o = sec_tick_o;
   end else begin : g_fast_div
      localparam int unsigned FST_W = $clog2(FAST_PERIOD);
      localparam logic [FST_W-1:0] FST_LAST = FST_W'(FAST_PERIOD - 1);
      logic [FST_W-1:0] fst_q;
      assign fast_tick_o = (fst_q == FST_LAST) && !load_i;
      always_ff @(posedge clk) begin
         if (!rst_n || load_i || fst_q == FST_LAST || at_last) begin
            fst_q <= '0;
         end else begin
            fst_q <= fst_q + FST_W'(1);
         end
      end
   end

   // R2
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (count_o == $past(load_val_i)));
   // R3
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick_o |=> (count_o == $past(count_o) + TIME_W'(1)));
   // R3
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick_o && !load_i) |=> $stable(count_o));

endmodule

// File: rtl/rtc_alarm_events.sv
module rtc_alarm_events
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick_i,
   input  logic              fast_tick_i,
   input  logic [TIME_W-1:0] count_i,
   input  logic              wr_cfg_i,
   input  logic              wr_alarm_i,
   input  logic              wr_status_i,
   input  logic [TIME_W-1:0] wdata_i,
   output icfg_t             cfg_o,
   output logic [TIME_W-1:0] alarm_o,
   output logic [1:0]        status_o,
   output logic              event_o
);
   icfg_t             cfg_q;
   logic [TIME_W-1:0] alarm_q;
   logic              st_q;
   logic              match;
   logic              per_hit;
   logic              ack;

   assign match   = cfg_q.alm_en && sec_tick_i &&
                    ((count_i + TIME_W'(1)) == alarm_q);
   assign per_hit = cfg_q.per_en &&
                    (cfg_q.rate_1hz ? sec_tick_i : fast_tick_i);
   assign event_o = match || per_hit;
   assign ack     = wr_status_i && wdata_i[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         alarm_q <= '0;
         st_q    <= 1'b0;
      end else begin
         if (wr_cfg_i)   cfg_q   <= icfg_t'(wdata_i[2:0]);
         if (wr_alarm_i) alarm_q <= wdata_i;
         if (event_o)    st_q    <= 1'b1;
         else if (ack)   st_q    <= 1'b0;
      end
   end

   assign cfg_o    = cfg_q;
   assign alarm_o  = alarm_q;
   assign status_o = {1'b0, st_q};

   // R6
   set_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[0]) |-> ($past(cfg_o) != 3'b000));
   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !event_o) |=> !status_o[0]);
   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |=> status_o[0]);
   // R7
   second_alarm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[1]);

endmodule

// File: rtl/rtc_irq_combiner.sv
module rtc_irq_combiner
   import rtc_alarm_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic               wr_i,
   input  logic [2*NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] cause_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic               irq_o
);
   logic [NUM_SRC-1:0] cause_q;
   logic [NUM_SRC-1:0] mask_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cause_q[s] <= 1'b0;
            mask_q[s]  <= 1'b0;
         end else begin
            if (set_i[s])                    cause_q[s] <= 1'b1;
            else if (wr_i && !wdata_i[s])    cause_q[s] <= 1'b0;
            if (wr_i) mask_q[s] <= wdata_i[NUM_SRC + s];
         end
      end

      // R8
      w0c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && !wdata_i[s] && !set_i[s]) |=> !cause_o[s]);
      // R8
      w1_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!cause_o[s] && !set_i[s]) |=> !cause_o[s]);
   end

   assign cause_o = cause_q;
   assign mask_o  = mask_q;
   assign irq_o   = |(cause_q & mask_q);

   // R9
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o == '0) |-> !irq_o);

endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned CLKS_PER_SEC = 32768,
   parameter int unsigned FAST_PERIOD  = 256,
   parameter int unsigned TIME_W       = 32,
   parameter int unsigned ADDR_W       = 8,
   parameter bit          READ_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sys,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_o
);
   if (TIME_W < 2 || TIME_W > BUS_W) begin : g_bad_tw
      $error("TIME_W must lie in 2..32");
   end
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_aw
      $error("ADDR_W must lie in 5..8");
   end

   reg_sel_e          sel;
   logic              wr_status, wr_cfg, wr_time, wr_alarm, wr_sys;
   logic [TIME_W-1:0] count;
   logic              sec_tick, fast_tick, evt;
   icfg_t             cfg;
   logic [TIME_W-1:0] alarm;
   logic [1:0]        status;
   logic [NUM_SRC-1:0] cause, mask;
   logic [BUS_W-1:0]  rd_mux;

   always_comb begin
      sel = SEL_NONE;
      if (bus_sys) begin
         if (bus_addr == ADDR_W'(OFS_SYSINT)) sel = SEL_SYSINT;
      end else begin
         if      (bus_addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
         else if (bus_addr == ADDR_W'(OFS_ICFG))   sel = SEL_ICFG;
         else if (bus_addr == ADDR_W'(OFS_TIME))   sel = SEL_TIME;
         else if (bus_addr == ADDR_W'(OFS_ALARM))  sel = SEL_ALARM;
      end
   end

   assign wr_status = bus_wr && (sel == SEL_STATUS);
   assign wr_cfg    = bus_wr && (sel == SEL_ICFG);
   assign wr_time   = bus_wr && (sel == SEL_TIME);
   assign wr_alarm  = bus_wr && (sel == SEL_ALARM);
   assign wr_sys    = bus_wr && (sel == SEL_SYSINT);

   rtc_sec_timebase #(
      .CLKS_PER_SEC (CLKS_PER_SEC),
      .FAST_PERIOD  (FAST_PERIOD),
      .TIME_W       (TIME_W)
   ) u_tb (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (wr_time),
      .load_val_i  (bus_wdata[TIME_W-1:0]),
      .count_o     (count),
      .sec_tick_o  (sec_tick),
      .fast_tick_o (fast_tick)
   );

   rtc_alarm_events #(
      .TIME_W (TIME_W)
   ) u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_tick_i  (sec_tick),
      .fast_tick_i (fast_tick),
      .count_i     (count),
      .wr_cfg_i    (wr_cfg),
      .wr_alarm_i  (wr_alarm),
      .wr_status_i (wr_status),
      .wdata_i     (bus_wdata[TIME_W-1:0]),
      .cfg_o       (cfg),
      .alarm_o     (alarm),
      .status_o    (status),
      .event_o     (evt)
   );

   rtc_irq_combiner u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   ({1'b0, evt}),
      .wr_i    (wr_sys),
      .wdata_i (bus_wdata[2*NUM_SRC-1:0]),
      .cause_o (cause),
      .mask_o  (mask),
      .irq_o   (irq_o)
   );

   always_comb begin
      unique case (sel)
         SEL_STATUS: rd_mux = BUS_W'(status);
         SEL_ICFG:   rd_mux = BUS_W'(cfg);
         SEL_TIME:   rd_mux = BUS_W'(count);
         SEL_ALARM:  rd_mux = BUS_W'(alarm);
         SEL_SYSINT: rd_mux = BUS_W'({mask, cause});
         default:    rd_mux = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_reg
      logic [BUS_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      rdata_q <= '0;
         else if (bus_rd) rdata_q <= rd_mux;
      end
      assign bus_rdata = rdata_q;

      // R10
      unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));
      // R11
      cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && sel == SEL_ICFG) |=> (bus_rdata[BUS_W-1:3] == '0));
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end

endmodule

// File: tb/sim_rtc_alarm_core.sv
module sim_rtc_alarm_core;
   localparam int CLK_PERIOD = 10;
   localparam int CPS  = 8;
   localparam int FAST = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sys = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_alarm_core #(.CLKS_PER_SEC(CPS), .FAST_PERIOD(FAST)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sys(bus_sys), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o));

   typedef struct packed {
      logic        is_wr;
      logic        sys;
      logic [7:0]  addr;
      logic [31:0] data;   // write data or expected read data
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 8'h00, 32'h0,        8'd1 },  // R1 status
      '{1'b0, 1'b0, 8'h04, 32'h0,        8'd1 },  // R1 config
      '{1'b0, 1'b0, 8'h10, 32'h0,        8'd1 },  // R1 alarm
      '{1'b0, 1'b1, 8'h08, 32'h0,        8'd1 },  // R1 system word
      '{1'b1, 1'b0, 8'h10, 32'hDEADBEEF, 8'd11},  // R11
      '{1'b0, 1'b0, 8'h10, 32'hDEADBEEF, 8'd11},
      '{1'b1, 1'b0, 8'h04, 32'hFFFFFFF8, 8'd11},  // R11 upper bits dropped
      '{1'b0, 1'b0, 8'h04, 32'h0,        8'd11},
      '{1'b1, 1'b1, 8'h08, 32'h0000000C, 8'd9 },  // R9 masks
      '{1'b0, 1'b1, 8'h08, 32'h0000000C, 8'd9 },
      '{1'b1, 1'b1, 8'h08, 32'h00000003, 8'd8 },  // R8 write 1 does not set
      '{1'b0, 1'b1, 8'h08, 32'h0,        8'd8 },
      '{1'b0, 1'b0, 8'h14, 32'h0,        8'd10},  // R10 unmapped
      '{1'b1, 1'b0, 8'h14, 32'hFFFFFFFF, 8'd10},
      '{1'b0, 1'b0, 8'h10, 32'hDEADBEEF, 8'd10},
      '{1'b0, 1'b1, 8'h00, 32'h0,        8'd10},  // R10 system region hole
      '{1'b1, 1'b0, 8'h00, 32'hFFFFFFFF, 8'd7 }   // R7 ack with nothing set
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sys, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sys = sys; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic sys, input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sys = sys; bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
   end

   initial begin
      logic [31:0] d;
      int waited;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      rd(1'b0, 8'h0C, d);
      chk("R1 time", d, 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_wr) begin
            wr(VEC[i].sys, VEC[i].addr, VEC[i].data);
         end else begin
            rd(VEC[i].sys, VEC[i].addr, d);
            chk($sformatf("R%0d vec%0d", VEC[i].req, i), d, VEC[i].data);
         end
      end
      rd(1'b0, 8'h00, d);
      chk("R7 status after empty ack", d, 32'h0);

      // R2 R3: load restarts prescaler, wrap to zero
      wr(1'b0, 8'h0C, 32'hFFFFFFFF);
      repeat (CPS-1) @(negedge clk);
      bus_sys = 1'b0; bus_addr = 8'h0C; bus_rd = 1'b1;
      @(negedge clk);
      chk("R2 no step before one second", bus_rdata, 32'hFFFFFFFF);
      @(negedge clk);
      chk("R3 wrap after one second", bus_rdata, 32'h0);
      bus_rd = 1'b0;

      // R4 alarm match, two-layer acknowledge
      wr(1'b0, 8'h10, 32'd102);
      wr(1'b0, 8'h04, 32'h1);
      wr(1'b1, 8'h08, 32'h4);
      wr(1'b0, 8'h0C, 32'd100);
      chk("R4 no irq before match", {31'b0, irq_o}, 32'h0);
      waited = 0;
      while (!irq_o && waited < 60) begin
         @(negedge clk);
         waited++;
      end
      chk("R4 irq two seconds after load", waited, 2*CPS);
      rd(1'b0, 8'h0C, d);
      chk("R4 time equals alarm", d, 32'd102);
      rd(1'b0, 8'h00, d);
      chk("R4 status set", d, 32'h1);
      rd(1'b1, 8'h08, d);
      chk("R8 cause set", d, 32'h5);
      wr(1'b0, 8'h00, 32'h1);
      rd(1'b0, 8'h00, d);
      chk("R7 status acked", d, 32'h0);
      chk("R9 irq held by cause", {31'b0, irq_o}, 32'h1);
      wr(1'b1, 8'h08, 32'h4);
      chk("R8 irq drops after cause clear", {31'b0, irq_o}, 32'h0);
      rd(1'b1, 8'h08, d);
      chk("R8 cause cleared", d, 32'h4);

      // R9 masked source: cause sets, irq stays low
      wr(1'b1, 8'h08, 32'h0);
      wr(1'b0, 8'h04, 32'h6);
      repeat (2*CPS+2) @(negedge clk);
      chk("R9 masked irq low", {31'b0, irq_o}, 32'h0);
      rd(1'b1, 8'h08, d);
      chk("R9 cause set while masked", d, 32'h1);

      // R5 one event per second
      wr(1'b0, 8'h0C, 32'd500);
      wr(1'b0, 8'h00, 32'h1);
      rd(1'b0, 8'h00, d);
      chk("R5 1Hz quiet mid-second", d, 32'h0);
      repeat (CPS) @(negedge clk);
      rd(1'b0, 8'h00, d);
      chk("R5 1Hz event on tick", d, 32'h1);

      // R5 fast rate; ack collides with an event, set wins (R7)
      wr(1'b0, 8'h04, 32'h2);
      wr(1'b0, 8'h0C, 32'd700);
      wr(1'b0, 8'h00, 32'h1);
      rd(1'b0, 8'h00, d);
      chk("R5 fast event early in second", d, 32'h1);

      // R6 configuration zero blocks alarm and periodic events
      wr(1'b0, 8'h04, 32'h0);
      wr(1'b1, 8'h08, 32'h4);
      wr(1'b0, 8'h0C, 32'd900);
      wr(1'b0, 8'h10, 32'd901);
      wr(1'b0, 8'h00, 32'h1);
      repeat (3*CPS) @(negedge clk);
      rd(1'b0, 8'h00, d);
      chk("R6 status stays clear", d, 32'h0);
      rd(1'b1, 8'h08, d);
      chk("R6 cause stays clear", d, 32'h4);
      chk("R6 irq low", {31'b0, irq_o}, 32'h0);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(1'b0, 8'h0C, d);
      chk("R1 time after reset", d, 32'h0);
      rd(1'b1, 8'h08, d);
      chk("R1 system word after reset", d, 32'h0);
      rd(1'b0, 8'h10, d);
      chk("R1 alarm after reset", d, 32'h0);

      finish_up();
   end
endmodule